// File: doc/BRIEF.md
# CAN Receiver Status Flag Register

This block keeps eight sticky event flags for the receive side of a CAN controller and turns them into one maskable interrupt. It watches the receive and transmit error counters, an overrun indication, a receive-buffer-full level and bus activity seen while the controller sleeps. Each flag sets on entry into its condition. The two warning flags are held back while a more severe error-passive or bus-off flag is already set.

Software reaches the block through a small register port. Address 0 is the flag register, which can only be read or cleared with write-one-to-clear. Address 1 is the interrupt-enable register. A clear is refused while the flag's cause is still present.

A three-state sleep controller tracks low-power mode. ST_AWAKE moves to ST_ASLEEP when a sleep request is seen. ST_ASLEEP moves to ST_WAKE_HOLD on bus activity, which raises the wake-up flag. It returns to ST_AWAKE if the request is withdrawn. ST_WAKE_HOLD moves to ST_AWAKE once the request drops.

Top module: `can_rx_status_flags`

## Requirements
- R1: The flag register (reg_addr=0) holds, from bit 7 down to bit 0: wake-up, receive warning, transmit warning, receive error-passive, transmit error-passive, bus-off, overrun, receive-buffer-full. reg_rdata shows the flags when reg_addr=0 and the enable register when reg_addr=1, with no delay.
- R2: Writing 1 to a bit of the flag register requests a clear of that flag. A 0 bit leaves the flag unchanged, and flags never change through software writes in any other way.
- R3: A clear request is refused while the flag's cause is present. The causes are: the counter above its threshold, overrun high, rx_full high, or the wake event in that cycle.
- R4: The receive warning flag (bit 6) sets when rec rises above 96, but only if bits 4, 3 and 2 are all clear.
- R5: The transmit warning flag (bit 5) sets when tec rises above 96, under the same suppression by bits 4, 3 and 2.
- R6: Bit 4 sets when rec rises above 127, and bit 3 sets when tec rises above 127. Bit 2 sets when tec rises above 255. Each of these sets on entry into its condition only.
- R7: In ST_ASLEEP, bus_act sets the wake-up flag and leaves sleep (sleep_ack falls). The controller stays out of sleep in ST_WAKE_HOLD until sleep_req drops.
- R8: irq is 1 one cycle after any flag is set while its enable bit is 1, and 0 one cycle after no enabled flag is set.
- R9: A hard reset clears flags, enables and the sleep state. soft_rst clears all flags and returns to ST_AWAKE, and it leaves the enables unchanged.
- R10: When a set event and a clear request for the same flag meet in one cycle, the flag ends up set.
- R11: The overrun flag (bit 1) and the buffer-full flag (bit 0) set on the rising edge of overrun and rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| soft_rst | input | 1 | Synchronous soft reset of flags and sleep state |
| sleep_req | input | 1 | Request to enter sleep mode |
| bus_act | input | 1 | Bus activity detected |
| rec | input | 9 | Receive error counter |
| tec | input | 9 | Transmit error counter |
| overrun | input | 1 | Receive overrun condition |
| rx_full | input | 1 | Receive buffer full |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flags, 1 = enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| sleep_ack | output | 1 | Controller is in sleep |
| irq | output | 1 | Registered combined interrupt |

## Verification
On every cycle, the assertions check that a flag only drops through an accepted write-one clear or a soft reset. They also check that a clear of a buffer-full flag with the level still high is refused, and that irq tracks the enabled flags of the previous cycle. Further checks cover warning suppression against the severe flags, wake-up only out of sleep, and the flags being empty after a soft reset. The bench scenarios are needed to show the threshold crossings themselves and edge-only setting once a cause persists. They also cover the suppressed warnings under combined counter moves, the three-state sleep walk, set-beats-clear in the wake cycle, and enables surviving a soft reset.

// File: rtl/can_rxflag_pkg.sv
package can_rxflag_pkg;
    localparam int NFLAG = 8;
    localparam int B_WAKE = 7;
    localparam int B_RWRN = 6;
    localparam int B_TWRN = 5;
    localparam int B_RXEP = 4;
    localparam int B_TXEP = 3;
    localparam int B_BOFF = 2;
    localparam int B_OVR  = 1;
    localparam int B_RXF  = 0;

    typedef enum logic [1:0] {
        ST_AWAKE     = 2'd0,
        ST_ASLEEP    = 2'd1,
        ST_WAKE_HOLD = 2'd2
    } sleep_st_t;
endpackage

// File: rtl/can_rxflag_sleep_fsm.sv
module can_rxflag_sleep_fsm
    import can_rxflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic sleep_req,
    input  logic bus_act,
    output logic sleep_ack,
    output logic wake_evt
);
    sleep_st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_AWAKE;
        else if (soft_rst) state_q <= ST_AWAKE;
        else               state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:     if (sleep_req) state_d = ST_ASLEEP;
            ST_ASLEEP:    if (bus_act) state_d = ST_WAKE_HOLD;
                          else if (!sleep_req) state_d = ST_AWAKE;
            ST_WAKE_HOLD: if (!sleep_req) state_d = ST_AWAKE;
            default:      state_d = ST_AWAKE;
        endcase
    end

    always_comb begin
        sleep_ack = (state_q == ST_ASLEEP);
        wake_evt  = (state_q == ST_ASLEEP) && bus_act;
    end
endmodule

// File: rtl/can_rxflag_cause.sv
module can_rxflag_cause
    import can_rxflag_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int EP_LIM   = 127,
    parameter int BOFF_LIM = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_evt,
    input  logic [CNT_W-1:0] rec,
    input  logic [CNT_W-1:0] tec,
    input  logic             overrun,
    input  logic             rx_full,
    input  logic [NFLAG-1:0] flags_i,
    output logic [NFLAG-1:0] set_o,
    output logic [NFLAG-1:0] hold_o
);
    localparam int CW = CNT_W + 1;
    logic [NFLAG-1:0] cond, cond_q, rise;
    logic             severe;

    always_comb begin
        cond          = '0;
        cond[B_WAKE]  = wake_evt;
        cond[B_RWRN]  = CW'(rec) > CW'(WARN_LIM);
        cond[B_TWRN]  = CW'(tec) > CW'(WARN_LIM);
        cond[B_RXEP]  = CW'(rec) > CW'(EP_LIM);
        cond[B_TXEP]  = CW'(tec) > CW'(EP_LIM);
        cond[B_BOFF]  = CW'(tec) > CW'(BOFF_LIM);
        cond[B_OVR]   = overrun;
        cond[B_RXF]   = rx_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    assign rise   = cond & ~cond_q;
    assign severe = flags_i[B_RXEP] | flags_i[B_TXEP] | flags_i[B_BOFF];

    always_comb begin
        set_o = rise;
        if (severe) begin
            set_o[B_RWRN] = 1'b0;
            set_o[B_TWRN] = 1'b0;
        end
    end

    assign hold_o = cond;
endmodule

// File: rtl/can_rxflag_bank.sv
module can_rxflag_bank
    import can_rxflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] hold_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic             en_wr,
    input  logic [NFLAG-1:0] en_wdata,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] en_o
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     f_q <= 1'b0;
            else if (soft_rst)              f_q <= 1'b0;
            else if (set_i[i])              f_q <= 1'b1;
            else if (clr_i[i] && !hold_i[i]) f_q <= 1'b0;
        end
        assign flags_o[i] = f_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_o <= '0;
        else if (en_wr) en_o <= en_wdata;
    end
endmodule

// File: rtl/can_rx_status_flags.sv
module can_rx_status_flags
    import can_rxflag_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int EP_LIM   = 127,
    parameter int BOFF_LIM = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             sleep_req,
    input  logic             bus_act,
    input  logic [CNT_W-1:0] rec,
    input  logic [CNT_W-1:0] tec,
    input  logic             overrun,
    input  logic             rx_full,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             sleep_ack,
    output logic             irq
);
    logic             wake_evt;
    logic [NFLAG-1:0] set_v, hold_v, clr_v, flags_q, en_q;
    logic             en_wr;

    can_rxflag_sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .sleep_req(sleep_req), .bus_act(bus_act),
        .sleep_ack(sleep_ack), .wake_evt(wake_evt)
    );

    can_rxflag_cause #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .EP_LIM(EP_LIM), .BOFF_LIM(BOFF_LIM)
    ) u_cause (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt),
        .rec(rec), .tec(tec), .overrun(overrun), .rx_full(rx_full),
        .flags_i(flags_q), .set_o(set_v), .hold_o(hold_v)
    );

    assign clr_v = (reg_wr && !reg_addr) ? reg_wdata : '0;
    assign en_wr = reg_wr && reg_addr;

    can_rxflag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_i(set_v), .hold_i(hold_v), .clr_i(clr_v),
        .en_wr(en_wr), .en_wdata(reg_wdata),
        .flags_o(flags_q), .en_o(en_q)
    );

    assign reg_rdata = reg_addr ? en_q : flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags_q & en_q);
    end
endmodule

// File: rtl/can_rxflag_chk.sv
module can_rxflag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic       rx_full,
    input logic       sleep_ack,
    input logic       irq,
    input logic [7:0] flags_q,
    input logic [7:0] en_q
);
    for (genvar i = 0; i < 8; i++) begin : g_keep
        AST_ONLY_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !soft_rst && !(reg_wr && !reg_addr && reg_wdata[i])) |=> flags_q[i]); // R2
    end

    AST_CLEAR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && rx_full && reg_wr && !reg_addr && reg_wdata[0] && !soft_rst) |=> flags_q[0]); // R3

    AST_WARN_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[6]) |-> ($past(flags_q[4:2]) == 3'b000)); // R4

    AST_TWARN_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[5]) |-> ($past(flags_q[4:2]) == 3'b000)); // R5

    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[7]) |-> ($past(sleep_ack) && !sleep_ack)); // R7

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(flags_q & en_q)))); // R8

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags_q == 8'h00)); // R9
endmodule

bind can_rx_status_flags can_rxflag_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_full(rx_full), .sleep_ack(sleep_ack), .irq(irq),
    .flags_q(flags_q), .en_q(en_q)
);

// File: tb/can_rx_status_flags_bench.sv
`timescale 1ns/1ps
module can_rx_status_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       sleep_req = 1'b0;
    logic       bus_act = 1'b0;
    logic [8:0] rec = '0;
    logic [8:0] tec = '0;
    logic       overrun = 1'b0;
    logic       rx_full = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_ack;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    can_rx_status_flags u_can_rx_status_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .sleep_req(sleep_req), .bus_act(bus_act),
        .rec(rec), .tec(tec), .overrun(overrun), .rx_full(rx_full),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_ack(sleep_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic rd_flags(input string req, input logic [7:0] exp);
        reg_addr = 1'b0; #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        rd_flags("R9 reset flags", 8'h00);
        reg_addr = 1'b1; #1;
        check("R9 reset enables", reg_rdata, 8'h00);
        reg_addr = 1'b0;
        check("R9 reset irq/sleep", {6'b0, irq, sleep_ack}, 8'h00);
    endtask

    task automatic t_buffer_full();
        wr(1'b1, 8'h01);
        rx_full = 1'b1; tick();
        rd_flags("R11 rx_full sets bit0", 8'h01);
        tick();
        check("R8 irq one cycle later", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h01);
        rd_flags("R3 clear refused while full", 8'h01);
        wr(1'b0, 8'h00);
        rx_full = 1'b0; tick();
        rd_flags("R2 zero write no effect", 8'h01);
        wr(1'b0, 8'h01);
        rd_flags("R2 W1C clears bit0", 8'h00);
        tick();
        check("R8 irq drops", {7'b0, irq}, 8'h00);
        overrun = 1'b1; tick(); overrun = 1'b0; tick();
        rd_flags("R11 overrun sets bit1", 8'h02);
        tick();
        check("R8 masked flag no irq", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h02);
        rd_flags("R2 overrun cleared", 8'h00);
    endtask

    task automatic t_counters();
        tec = 9'd130; tick();
        rd_flags("R5 R6 tx warn and tx passive", 8'h28);
        wr(1'b0, 8'h28);
        rd_flags("R3 refused while tec high", 8'h28);
        rec = 9'd100; tick();
        rd_flags("R4 rx warn suppressed", 8'h28);
        tec = 9'd50; tick();
        wr(1'b0, 8'h28);
        rd_flags("R3 clear accepted after cause gone", 8'h00);
        tick();
        rd_flags("R6 no reset on persisting level", 8'h00);
        rec = 9'd50; tick(); rec = 9'd100; tick();
        rd_flags("R4 rx warn sets above 96", 8'h40);
        rec = 9'd200; tick();
        rd_flags("R6 rx passive above 127", 8'h50);
        tec = 9'd300; tick();
        rd_flags("R5 R6 bus-off, tx warn suppressed", 8'h5C);
        rec = '0; tec = '0; tick();
        wr(1'b0, 8'hFF);
        rd_flags("R2 all cleared", 8'h00);
    endtask

    task automatic t_sleep();
        sleep_req = 1'b1; tick();
        check("R7 enters sleep", {7'b0, sleep_ack}, 8'h01);
        bus_act = 1'b1; tick(); bus_act = 1'b0;
        rd_flags("R7 wake flag", 8'h80);
        check("R7 sleep left", {7'b0, sleep_ack}, 8'h00);
        tick();
        check("R7 held while request stays", {7'b0, sleep_ack}, 8'h00);
        sleep_req = 1'b0; tick();
        wr(1'b0, 8'h80);
        rd_flags("R2 wake cleared", 8'h00);
        sleep_req = 1'b1; tick();
        check("R7 sleep again", {7'b0, sleep_ack}, 8'h01);
        bus_act = 1'b1;
        wr(1'b0, 8'h80);
        bus_act = 1'b0; sleep_req = 1'b0;
        rd_flags("R10 set beats clear", 8'h80);
        tick();
        wr(1'b0, 8'h80);
        rd_flags("R2 wake cleared later", 8'h00);
    endtask

    task automatic t_soft();
        wr(1'b1, 8'h81);
        rx_full = 1'b1; tick();
        rd_flags("R11 full again", 8'h01);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        rd_flags("R9 soft reset clears flags", 8'h00);
        reg_addr = 1'b1; #1;
        check("R1 R9 enables survive soft reset", reg_rdata, 8'h81);
        reg_addr = 1'b0;
        rx_full = 1'b0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_buffer_full();
        t_counters();
        t_sleep();
        t_soft();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule